// File: doc/BRIEF.md
# Dual-Mode FIFO Read Port

This block is a dual-clock FIFO whose read side can present data in one of two ways, chosen by a static mode input. In standard mode the read port behaves like a plain queue: a word moves to the registered data output only when the reader asserts its active-low read enable. A status pin is high while stored data remains, and low when the queue is empty. In fall-through mode the oldest stored word is moved into the output register without any request. The same status pin then reads low while that register holds a valid word. Pulling the read enable low consumes the displayed word, and the next one, if any, replaces it at the same edge.

Words are written on the write clock into a block-RAM style memory of `2**ADDR_W` words. Both pointers cross clock domains as Gray codes through two-flop synchronisers. Because the output register counts as a storage slot in fall-through mode, the queue then holds one word more than the memory depth. A registered full flag on the write side blocks any write that would overrun the memory. The mode pin may only change while reset is held. A single synchronous active-high reset serves both domains and must be held across at least three edges of each clock.

Top module: `fifo_read_port`

## Requirements
- R1: While reset is applied and after it is released with nothing written, `rd_data` is zero and `wr_full` is 0. `rd_stat_n` is 0 in standard mode (`fwft_mode`=0) and 1 in fall-through mode (`fwft_mode`=1).
- R2: In standard mode, with both clocks tied together, a word written at edge k makes `rd_stat_n` rise after edge k+3. Until then it stays 0.
- R3: In standard mode, an edge where `rd_en_n`=0 and `rd_stat_n`=1 loads the oldest unread word into `rd_data`. Words come out in write order.
- R4: In standard mode, `rd_stat_n` falls at the same edge that reads the last stored word. A read request while `rd_stat_n`=0 leaves `rd_data` unchanged.
- R5: In fall-through mode, with both clocks tied together, a word written at edge k into an empty queue appears on `rd_data` after edge k+4, with no read request. `rd_stat_n` falls at that same edge.
- R6: In fall-through mode, while `rd_stat_n`=0, `rd_data` always shows the oldest unread word. An edge with `rd_en_n`=0 consumes it and shows the next stored word after that edge.
- R7: In fall-through mode, `rd_stat_n` rises only at an edge with `rd_en_n`=0 that consumes the last word. That word stays on `rd_data`, and read requests are ignored until a new word arrives.
- R8: With no reads, `wr_full` rises once the queue holds its capacity: `2**ADDR_W` words in standard mode and `2**ADDR_W`+1 words in fall-through mode.
- R9: A write while `wr_full`=1 is discarded. Draining the queue returns exactly the capacity, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset for both domains |
| fwft_mode | input | 1 | 0 = standard read, 1 = fall-through read; static outside reset |
| wr_en | input | 1 | Write request, active high |
| wr_data | input | DATA_W (18) | Word to store |
| wr_full | output | 1 | Registered full flag, write domain |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | DATA_W (18) | Registered output word |
| rd_stat_n | output | 1 | Standard: 1 = data stored, 0 = empty. Fall-through: 0 = `rd_data` valid, 1 = not valid |

## Verification
With both clocks tied together, the synchroniser depth is fixed. A written word therefore raises the standard-mode status pin three edges after the write edge, and shows up in fall-through mode four edges after it. The bench samples at the falling edge after each of those edges and checks the exact cycle at which the status changes.

A standard read's word is due one edge after the request, and it is compared at the next falling edge. A fall-through head word is compared whenever the status pin shows it valid. A reference queue in the bench is pushed when a write meets a low `wr_full` and popped when a read meets an active status. That queue supplies every expected value during both the random traffic and the capacity drains.

// File: rtl/fifo_rdp_pkg.sv
package fifo_rdp_pkg;

  // Read presentation mode, taken from the static mode pin.
  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FALLTHRU = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/fifo_dp_ram.sv
// Simple dual-port memory with a registered, resettable read port.
module fifo_dp_ram #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/gray_ptr_sync.sv
// Two-flop synchroniser for a Gray pointer, decoded to binary on the far side.
module gray_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_in;
      stab_q <= meta_q;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_dec
    assign bin_out[i] = ^(stab_q >> i);
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
// Write pointer, Gray export and registered full flag.
module fifo_wr_ctl #(
  parameter int AW = 4
) (
  input  logic        wr_clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] rbin_s,
  output logic        wr_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0] wgray,
  output logic        wr_full
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] wptr, wptr_nxt;

  assign wr_ok    = wr_en && !wr_full;
  assign wptr_nxt = wptr + PW'(wr_ok);
  assign wr_addr  = wptr[AW-1:0];

  always_ff @(posedge wr_clk) begin
    if (rst) begin
      wptr    <= '0;
      wgray   <= '0;
      wr_full <= 1'b0;
    end else begin
      wptr    <= wptr_nxt;
      wgray   <= wptr_nxt ^ (wptr_nxt >> 1);
      wr_full <= (wptr_nxt - rbin_s) == CAP;
    end
  end

  // R9: a write request against a full memory must not move the pointer
  p_full_blocks_r9: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_full && wr_en) |=> $stable(wptr));

  // R8: stored count seen from this side never exceeds the memory depth
  p_no_overrun_r8: assert property (@(posedge wr_clk) disable iff (rst)
    (wptr - rbin_s) <= CAP);
endmodule

// File: rtl/fifo_rd_ctl.sv
// Read pointer, memory-occupancy register and fall-through output tracking.
module fifo_rd_ctl
  import fifo_rdp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        rd_clk,
  input  logic        rst,
  input  rd_mode_e    mode,
  input  logic        rd_en_n,
  input  logic [AW:0] wbin_s,
  output logic        ram_rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0] rgray,
  output logic        stat_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] rptr, rptr_nxt;
  logic          mem_has;   // registered: memory holds an unread word
  logic          out_void;  // fall-through: output register empty (active-high "not ready")
  logic          std_go, ft_go, ft_last;

  assign std_go   = (mode == RD_STANDARD) && !rd_en_n && mem_has;
  assign ft_go    = (mode == RD_FALLTHRU) && mem_has && (out_void || !rd_en_n);
  assign ft_last  = (mode == RD_FALLTHRU) && !rd_en_n && !out_void && !mem_has;

  assign ram_rd_en = std_go || ft_go;
  assign rptr_nxt  = rptr + PW'(ram_rd_en);
  assign rd_addr   = rptr[AW-1:0];
  assign stat_n    = (mode == RD_FALLTHRU) ? out_void : mem_has;

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rptr     <= '0;
      rgray    <= '0;
      mem_has  <= 1'b0;
      out_void <= 1'b1;
    end else begin
      rptr    <= rptr_nxt;
      rgray   <= rptr_nxt ^ (rptr_nxt >> 1);
      mem_has <= (wbin_s != rptr_nxt);
      if (ft_go)        out_void <= 1'b0;
      else if (ft_last) out_void <= 1'b1;
    end
  end

  // R3: the read pointer never runs ahead of the synchronised write pointer
  p_no_underrun_r3: assert property (@(posedge rd_clk) disable iff (rst)
    (wbin_s - rptr) <= CAP);

  // R7: the output register only empties in fall-through mode on a read request
  p_ready_rise_r7: assert property (@(posedge rd_clk) disable iff (rst)
    $rose(out_void) |-> (mode == RD_FALLTHRU && $past(!rd_en_n)));
endmodule

// File: rtl/fifo_read_port.sv
// Dual-clock FIFO with selectable standard or fall-through read presentation.
module fifo_read_port
  import fifo_rdp_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              fwft_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_stat_n
);
  localparam int PW = ADDR_W + 1;

  rd_mode_e          mode;
  logic              wr_ok, ram_rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wgray, rgray, wbin_s, rbin_s;

  assign mode = rd_mode_e'(fwft_mode);

  fifo_wr_ctl #(.AW(ADDR_W)) u_wr (
    .wr_clk (wr_clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rbin_s (rbin_s),
    .wr_ok  (wr_ok),
    .wr_addr(wr_addr),
    .wgray  (wgray),
    .wr_full(wr_full)
  );

  gray_ptr_sync #(.PW(PW)) u_rsync (
    .clk    (wr_clk),
    .rst    (rst),
    .gray_in(rgray),
    .bin_out(rbin_s)
  );

  gray_ptr_sync #(.PW(PW)) u_wsync (
    .clk    (rd_clk),
    .rst    (rst),
    .gray_in(wgray),
    .bin_out(wbin_s)
  );

  fifo_rd_ctl #(.AW(ADDR_W)) u_rd (
    .rd_clk   (rd_clk),
    .rst      (rst),
    .mode     (mode),
    .rd_en_n  (rd_en_n),
    .wbin_s   (wbin_s),
    .ram_rd_en(ram_rd_en),
    .rd_addr  (rd_addr),
    .rgray    (rgray),
    .stat_n   (rd_stat_n)
  );

  fifo_dp_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wr_clk (wr_clk),
    .wr_en  (wr_ok),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_clk (rd_clk),
    .rd_rst (rst),
    .rd_en  (ram_rd_en),
    .rd_addr(rd_addr),
    .rd_q   (rd_data)
  );

  // R4: in standard mode an empty status freezes the output word
  p_empty_hold_r4: assert property (@(posedge rd_clk) disable iff (rst)
    (!fwft_mode && !rd_stat_n) |=> $stable(rd_data));

  // R7: in fall-through mode a not-ready output only changes together with becoming ready
  p_unready_hold_r7: assert property (@(posedge rd_clk) disable iff (rst)
    (fwft_mode && rd_stat_n) |=> ($stable(rd_data) || !rd_stat_n));
endmodule

// File: tb/fifo_read_port_tb_top.sv
module fifo_read_port_tb_top;
  localparam int DW    = 18;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fwft_mode = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en_n = 1'b1;
  logic          wr_full;
  logic [DW-1:0] rd_data;
  logic          rd_stat_n;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_word;
  bit            pend = 0;

  always #10 clk = ~clk;  // 50 MHz

  fifo_read_port #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .wr_clk   (clk),
    .rd_clk   (clk),
    .rst      (rst),
    .fwft_mode(fwft_mode),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_full  (wr_full),
    .rd_en_n  (rd_en_n),
    .rd_data  (rd_data),
    .rd_stat_n(rd_stat_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic bit avail();
    return fwft_mode ? !rd_stat_n : rd_stat_n;
  endfunction

  // One clock: drive at the falling edge, advance, then check at the next falling edge.
  task automatic step(input logic we, input logic [DW-1:0] wd, input logic rn);
    wr_en   = we;
    wr_data = wd;
    rd_en_n = rn;
    if (!rn && avail()) begin
      if (q.size() == 0) chk(0, fwft_mode ? "R6" : "R3", 32'(q.size()), 32'd1);
      else begin
        exp_word = q.pop_front();
        if (!fwft_mode) pend = 1;
      end
    end
    if (we && !wr_full) q.push_back(wd);
    @(posedge clk);
    @(negedge clk);
    if (pend) begin
      chk(rd_data == exp_word, "R3", 32'(rd_data), 32'(exp_word));
      pend = 0;
    end
    if (fwft_mode && !rd_stat_n) begin
      if (q.size() == 0) chk(0, "R6", 32'(rd_data), 32'hFFFFFFFF);
      else chk(rd_data == q[0], "R6", 32'(rd_data), 32'(q[0]));
    end
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; fwft_mode = m; wr_en = 1'b0; rd_en_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q.delete();
    pend = 0;
    chk(rd_data == '0, "R1", 32'(rd_data), 32'd0);
    chk(wr_full == 1'b0, "R1", 32'(wr_full), 32'd0);
    chk(rd_stat_n == m, "R1", 32'(rd_stat_n), 32'(m));
  endtask

  task automatic drain(input int expn, input string req);
    int n = 0;
    int idle = 0;
    while (idle < 10) begin
      if (avail()) begin step(1'b0, '0, 1'b0); n++; idle = 0; end
      else begin step(1'b0, '0, 1'b1); idle++; end
    end
    chk(n == expn && q.size() == 0, req, 32'(n), 32'(expn));
  endtask

  task automatic run_random(input int n, input int wpct, input int rpct);
    for (int i = 0; i < n; i++) begin
      step(($urandom % 100) < wpct, DW'($urandom), !(($urandom % 100) < rpct));
    end
  endtask

  task automatic fill_capacity();
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, DW'(18'h100 + i), 1'b1);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    do_reset(1'b0);

    // standard mode: flag latency, read, empty behaviour
    step(1'b1, 18'h2A5A5, 1'b1);
    chk(rd_stat_n == 1'b0, "R2", 32'(rd_stat_n), 0);
    for (int i = 0; i < 2; i++) begin
      step(1'b0, '0, 1'b1);
      chk(rd_stat_n == 1'b0, "R2", 32'(rd_stat_n), 0);
    end
    step(1'b0, '0, 1'b1);
    chk(rd_stat_n == 1'b1, "R2", 32'(rd_stat_n), 1);
    step(1'b0, '0, 1'b0);
    chk(rd_stat_n == 1'b0, "R4", 32'(rd_stat_n), 0);
    step(1'b0, '0, 1'b0);
    chk(rd_data == 18'h2A5A5, "R4", 32'(rd_data), 32'h2A5A5);

    step(1'b1, 18'h00B0B, 1'b1);
    step(1'b1, 18'h00C0C, 1'b1);
    step(1'b1, 18'h00D0D, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0);
    chk(rd_data == 18'h00D0D, "R3", 32'(rd_data), 32'h00D0D);
    chk(rd_stat_n == 1'b0, "R4", 32'(rd_stat_n), 0);

    fill_capacity();
    chk(wr_full == 1'b1, "R8", 32'(wr_full), 1);
    drain(DEPTH, "R9");

    run_random(700, 70, 30);
    run_random(700, 30, 70);
    run_random(700, 50, 50);
    drain(q.size(), "R3");

    // fall-through mode
    do_reset(1'b1);
    step(1'b1, 18'h3C3C3, 1'b1);
    chk(rd_stat_n == 1'b1, "R5", 32'(rd_stat_n), 1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 1'b1);
      chk(rd_stat_n == 1'b1, "R5", 32'(rd_stat_n), 1);
    end
    step(1'b0, '0, 1'b1);
    chk(rd_stat_n == 1'b0, "R5", 32'(rd_stat_n), 0);
    chk(rd_data == 18'h3C3C3, "R5", 32'(rd_data), 32'h3C3C3);
    for (int i = 0; i < 2; i++) begin
      step(1'b0, '0, 1'b0);
      chk(rd_stat_n == 1'b1, "R7", 32'(rd_stat_n), 1);
      chk(rd_data == 18'h3C3C3, "R7", 32'(rd_data), 32'h3C3C3);
    end

    step(1'b1, 18'h0B0B0, 1'b1);
    step(1'b1, 18'h0C0C0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1);
    chk(!rd_stat_n && rd_data == 18'h0B0B0, "R6", 32'(rd_data), 32'h0B0B0);
    step(1'b0, '0, 1'b0);
    chk(!rd_stat_n && rd_data == 18'h0C0C0, "R6", 32'(rd_data), 32'h0C0C0);
    step(1'b0, '0, 1'b0);
    chk(rd_stat_n && rd_data == 18'h0C0C0, "R7", 32'(rd_data), 32'h0C0C0);

    fill_capacity();
    chk(wr_full == 1'b1, "R8", 32'(wr_full), 1);
    drain(DEPTH + 1, "R9");

    run_random(700, 70, 30);
    run_random(700, 30, 70);
    run_random(700, 50, 50);
    drain(q.size(), "R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule